// File: doc/BRIEF.md
# Selectable-Order CIC Decimation Filter

This block turns a strobed single-bit delta-sigma stream into signed multi-bit results. Each accepted input bit is mapped to +1 or -1 and fed into a cascade of integrators. At the decimated rate, a matching cascade of comb stages produces the filter output. The filter order can be one, two or three, chosen at run time. A programmed offset is subtracted from each output before it is stored. Storing a result sets a sticky event flag and can also raise a one-cycle service request.

All configuration is taken in one cycle through a load strobe. A legal load replaces the active settings and clears the whole filter state. An illegal load is discarded. A start value places the first decimation point, and a settling phase of one decimation period per filter stage suppresses the early outputs. A second instance with a small decimation factor can be used as a fast path, for example for overcurrent detection.

Top module: `cic_demod_filter`

## Requirements
- R1: `cfgOrder` selects the order N: code 0 gives N=1, code 1 gives N=2 and code 2 gives N=3. An input bit of 1 counts as +1 and a bit of 0 counts as -1. The unoffset output equals the input convolved N times with a boxcar of length D. Samples before the last accepted load count as zero.
- R2: `cfgDecM1` holds D-1. A load is legal only when this field is greater than 3 and less than 255, so D runs from 5 to 255. Order code 3 is also illegal. An illegal load changes nothing.
- R3: `cfgStart` (S) must be at least 4, or the load is rejected. Counting accepted samples from 1 after a load, decimation points fall on samples S, S+D, S+2D and so on. The first N points only settle the combs. Results are stored on samples S+N*D+k*D.
- R4: The signed 16-bit `cfgOffset` is subtracted from the filter output before the result is stored.
- R5: `resultFlag` is set in the cycle after a storing sample. It stays set until an `evtClear` pulse with no result in the same cycle. A result wins over a simultaneous clear. `result` changes only when a result is stored.
- R6: When `cfgSrEn` was 1 at the last accepted load, `srReq` is a single-cycle pulse aligned with each stored result. Otherwise `srReq` stays 0.
- R7: While `runEn` is 0 or `sampleValid` is 0, the input bit is ignored. It is neither integrated nor counted.
- R8: An accepted load clears the integrators, combs, decimation counter and settling count. A sample presented in any cycle with `cfgLoad` high is dropped.
- R9: `result` is 3*DEC_W+1 = 25 bits wide. A third-order filter with D=255 and an all-ones input stores exactly 255^3 = 16581375.
- R10: After reset, `result`, `resultFlag` and `srReq` are 0. The active configuration is third order, D=16, S=4, offset 0, with the service request disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Load strobe for the configuration inputs |
| cfgOrder | input | 2 | Order code: 0, 1 or 2 for first, second or third order |
| cfgDecM1 | input | DEC_W | Decimation factor minus one |
| cfgStart | input | START_W | Sample index of the first decimation point |
| cfgOffset | input | OFF_W | Signed offset subtracted from each output |
| cfgSrEn | input | 1 | Enables the service-request pulse |
| runEn | input | 1 | Filter run enable |
| sampleValid | input | 1 | Strobe marking a new input bit |
| sampleBit | input | 1 | Input bit |
| evtClear | input | 1 | Write-one-to-clear for the event flag |
| result | output | 3*DEC_W+1 | Last stored signed result |
| resultFlag | output | 1 | Sticky new-result flag |
| srReq | output | 1 | Service-request pulse |

## Verification
The bound checker watches every cycle for the following:
- the service request only appears while the flag is set, and never on two cycles in a row;
- the flag only falls after a clear;
- the result only moves together with the flag;
- an idle or disabled cycle never changes the result.

Other behaviour needs the bench's scenarios and its convolution model:
- the numeric response for each order;
- the exact sample on which results appear for a given start value and decimation;
- offset subtraction;
- rejection of boundary-illegal loads;
- state clearing on reload;
- full-scale accuracy at D=255.

// File: rtl/cic_demod_pkg.sv
package cic_demod_pkg;

  // Order codes as seen on cfgOrder; code 3 is illegal
  typedef enum logic [1:0] {
    ORD1 = 2'd0,
    ORD2 = 2'd1,
    ORD3 = 2'd2
  } cicOrder_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;    // wipe filter state
    logic integ;    // accept one input bit
    logic tick;     // decimation point: comb stages advance
    logic publish;  // store a result
  } cicStb_t;

endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_demod_pkg::*;
#(
  parameter int DEC_W   = 8,
  parameter int START_W = 8,
  parameter int OFF_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgLoad,
  input  logic [1:0]         cfgOrder,
  input  logic [DEC_W-1:0]   cfgDecM1,
  input  logic [START_W-1:0] cfgStart,
  input  logic [OFF_W-1:0]   cfgOffset,
  input  logic               cfgSrEn,
  input  logic               runEn,
  input  logic               sampleValid,
  input  logic               evtClear,
  output cicStb_t            stb,
  output cicOrder_t          actOrder,
  output logic [OFF_W-1:0]   actOffset,
  output logic               resultFlag,
  output logic               srReq
);

  localparam int CNT_W = (DEC_W > START_W) ? DEC_W : START_W;
  localparam logic [DEC_W-1:0]   DEF_DECM1 = DEC_W'(15);
  localparam logic [START_W-1:0] DEF_START = START_W'(4);

  logic [DEC_W-1:0] actDecM1;
  logic             actSrEn;
  logic [CNT_W-1:0] downCnt;
  logic [1:0]       settleCnt;
  logic             cfgLegal;
  logic             settled;

  assign cfgLegal = (cfgOrder != 2'd3) && (cfgDecM1 > DEC_W'(3)) &&
                    (cfgDecM1 != '1) && (cfgStart >= START_W'(4));
  assign settled  = (settleCnt == (2'(actOrder) + 2'd1));

  always_comb begin
    stb.clear   = cfgLoad & cfgLegal;
    stb.integ   = sampleValid & runEn & ~cfgLoad;
    stb.tick    = stb.integ & (downCnt == '0);
    stb.publish = stb.tick & settled;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actOrder  <= ORD3;
      actDecM1  <= DEF_DECM1;
      actOffset <= '0;
      actSrEn   <= 1'b0;
      downCnt   <= CNT_W'(DEF_START) - CNT_W'(1);
      settleCnt <= '0;
    end else if (stb.clear) begin
      actOrder  <= cicOrder_t'(cfgOrder);
      actDecM1  <= cfgDecM1;
      actOffset <= cfgOffset;
      actSrEn   <= cfgSrEn;
      downCnt   <= CNT_W'(cfgStart) - CNT_W'(1);
      settleCnt <= '0;
    end else if (stb.integ) begin
      if (downCnt == '0) begin
        downCnt <= CNT_W'(actDecM1);
        if (!settled) settleCnt <= settleCnt + 2'd1;
      end else begin
        downCnt <= downCnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultFlag <= 1'b0;
      srReq      <= 1'b0;
    end else begin
      resultFlag <= stb.publish | (resultFlag & ~evtClear);
      srReq      <= stb.publish & actSrEn;
    end
  end

endmodule

// File: rtl/cic_dp.sv
module cic_dp
  import cic_demod_pkg::*;
#(
  parameter int ACC_W   = 25,
  parameter int OFF_W   = 16,
  parameter int ORD_MAX = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  cicStb_t          stb,
  input  cicOrder_t        order,
  input  logic [OFF_W-1:0] offset,
  input  logic             sampleBit,
  output logic [ACC_W-1:0] result
);

  logic [ACC_W-1:0] integQ    [ORD_MAX];
  logic [ACC_W-1:0] integNext [ORD_MAX];
  logic [ACC_W-1:0] dlyQ      [ORD_MAX];
  logic [ACC_W-1:0] combIn    [ORD_MAX];
  logic [ACC_W-1:0] xin, tap, combOut, offExt;

  assign xin    = sampleBit ? ACC_W'(1) : '1;
  assign offExt = {{(ACC_W-OFF_W){offset[OFF_W-1]}}, offset};

  // Integrator chain: stage k adds the new value of stage k-1 in the same cycle
  always_comb begin
    logic [ACC_W-1:0] carry;
    carry = xin;
    tap   = '0;
    for (int k = 0; k < ORD_MAX; k++) begin
      carry        = integQ[k] + carry;
      integNext[k] = carry;
      if (k == int'(order)) tap = carry;
    end
  end

  // Comb chain: only the first N stages differentiate, the rest pass through
  always_comb begin
    logic [ACC_W-1:0] c;
    c = tap;
    for (int k = 0; k < ORD_MAX; k++) begin
      combIn[k] = c;
      if (k <= int'(order)) c = c - dlyQ[k];
    end
    combOut = c;
  end

  for (genvar k = 0; k < ORD_MAX; k++) begin : g_stage
    logic [ACC_W-1:0] intReg, dlyReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        intReg <= '0;
        dlyReg <= '0;
      end else if (stb.clear) begin
        intReg <= '0;
        dlyReg <= '0;
      end else begin
        if (stb.integ) intReg <= integNext[k];
        if (stb.tick)  dlyReg <= combIn[k];
      end
    end
    assign integQ[k] = intReg;
    assign dlyQ[k]   = dlyReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            result <= '0;
    else if (stb.publish) result <= combOut - offExt;
  end

endmodule

// File: rtl/cic_demod_filter.sv
module cic_demod_filter
  import cic_demod_pkg::*;
#(
  parameter int DEC_W   = 8,
  parameter int START_W = 8,
  parameter int OFF_W   = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgLoad,
  input  logic [1:0]             cfgOrder,
  input  logic [DEC_W-1:0]       cfgDecM1,
  input  logic [START_W-1:0]     cfgStart,
  input  logic [OFF_W-1:0]       cfgOffset,
  input  logic                   cfgSrEn,
  input  logic                   runEn,
  input  logic                   sampleValid,
  input  logic                   sampleBit,
  input  logic                   evtClear,
  output logic [3*DEC_W:0]       result,
  output logic                   resultFlag,
  output logic                   srReq
);

  localparam int ORD_MAX = 3;
  localparam int ACC_W   = ORD_MAX * DEC_W + 1;

  cicStb_t          stb;
  cicOrder_t        actOrder;
  logic [OFF_W-1:0] actOffset;

  cic_ctrl #(.DEC_W(DEC_W), .START_W(START_W), .OFF_W(OFF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgOrder(cfgOrder),
    .cfgDecM1(cfgDecM1), .cfgStart(cfgStart), .cfgOffset(cfgOffset),
    .cfgSrEn(cfgSrEn), .runEn(runEn), .sampleValid(sampleValid),
    .evtClear(evtClear), .stb(stb), .actOrder(actOrder),
    .actOffset(actOffset), .resultFlag(resultFlag), .srReq(srReq)
  );

  cic_dp #(.ACC_W(ACC_W), .OFF_W(OFF_W), .ORD_MAX(ORD_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .order(actOrder),
    .offset(actOffset), .sampleBit(sampleBit), .result(result)
  );

endmodule

// File: rtl/cic_demod_filter_chk.sv
module cic_demod_filter_chk #(
  parameter int ACC_W = 25
) (
  input logic             clk,
  input logic             rstN,
  input logic             runEn,
  input logic             sampleValid,
  input logic             evtClear,
  input logic [ACC_W-1:0] result,
  input logic             resultFlag,
  input logic             srReq
);

  a_r6_sr_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    srReq |-> resultFlag);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    srReq |=> !srReq);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resultFlag) |-> $past(evtClear));

  a_r5_result_flagged: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> resultFlag);

  a_r7_idle_no_result: assert property (@(posedge clk) disable iff (!rstN)
    !(runEn && sampleValid) |=> $stable(result));

endmodule

bind cic_demod_filter cic_demod_filter_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .sampleValid(sampleValid),
  .evtClear(evtClear), .result(result), .resultFlag(resultFlag),
  .srReq(srReq)
);

// File: tb/cic_demod_filter_bench.sv
module cic_demod_filter_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgLoad, cfgSrEn, runEn, sampleValid, sampleBit, evtClear;
  logic [1:0]  cfgOrder;
  logic [7:0]  cfgDecM1, cfgStart;
  logic [15:0] cfgOffset;
  logic [24:0] result;
  logic        resultFlag, srReq;

  always #4 clk = ~clk;

  cic_demod_filter u_cic_demod_filter (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgOrder(cfgOrder),
    .cfgDecM1(cfgDecM1), .cfgStart(cfgStart), .cfgOffset(cfgOffset),
    .cfgSrEn(cfgSrEn), .runEn(runEn), .sampleValid(sampleValid),
    .sampleBit(sampleBit), .evtClear(evtClear), .result(result),
    .resultFlag(resultFlag), .srReq(srReq)
  );

  int total = 0;
  int bad   = 0;
  int xs [0:4095];
  int h  [0:799];
  int hLen;
  int nS;
  int mN, mD, mS, mOff, mSr;
  int expRes, expFlag;

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  // Impulse response: boxcar of length mD convolved mN times
  function automatic void buildH();
    int t [0:799];
    hLen = 1;
    h[0] = 1;
    for (int s = 0; s < mN; s++) begin
      int nl;
      nl = hLen + mD - 1;
      for (int i = 0; i < nl; i++) begin
        t[i] = 0;
        for (int j = 0; j < mD; j++)
          if (i - j >= 0 && i - j < hLen) t[i] += h[i-j];
      end
      for (int i = 0; i < nl; i++) h[i] = t[i];
      hLen = nl;
    end
  endfunction

  function automatic int modelOut();
    int acc;
    acc = 0;
    for (int j = 0; j < hLen; j++)
      if (nS - j >= 1) acc += h[j] * xs[nS-j];
    return acc;
  endfunction

  task automatic doLoad(input int ord, input int decM1, input int st,
                        input int off, input int sr, input string tag);
    bit legal;
    @(negedge clk);
    cfgLoad = 1'b1; sampleValid = 1'b1; sampleBit = 1'b1; evtClear = 1'b0;
    cfgOrder = 2'(ord); cfgDecM1 = 8'(decM1); cfgStart = 8'(st);
    cfgOffset = 16'(off); cfgSrEn = 1'(sr);
    @(posedge clk); #2;
    legal = (ord != 3) && (decM1 > 3) && (decM1 < 255) && (st >= 4);
    if (legal) begin
      mN = ord + 1; mD = decM1 + 1; mS = st; mOff = off; mSr = sr;
      nS = 0;
      buildH();
    end
    check({tag, " R8 no sr on load"}, int'(srReq), 0);
    check({tag, " R8 flag kept on load"}, int'(resultFlag), expFlag);
  endtask

  task automatic doSample(input bit b, input bit vld, input bit clr,
                          input string tag);
    bit pub;
    int g;
    @(negedge clk);
    cfgLoad = 1'b0; sampleValid = vld; sampleBit = b; evtClear = clr;
    @(posedge clk); #2;
    pub = 1'b0;
    if (vld && runEn) begin
      nS++;
      xs[nS] = b ? 1 : -1;
      if (nS >= mS + mN * mD && ((nS - mS) % mD) == 0) pub = 1'b1;
    end
    if (pub) begin
      expRes  = modelOut() - mOff;
      expFlag = 1;
    end else if (clr) begin
      expFlag = 0;
    end
    g = $signed(result);
    check({tag, " R5 flag"}, int'(resultFlag), expFlag);
    check({tag, " R6 srReq"}, int'(srReq), (pub && mSr != 0) ? 1 : 0);
    check({tag, " result"}, g, expRes);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; cfgLoad = 1'b0; cfgSrEn = 1'b0; runEn = 1'b1;
    sampleValid = 1'b0; sampleBit = 1'b0; evtClear = 1'b0;
    cfgOrder = 2'd2; cfgDecM1 = 8'd15; cfgStart = 8'd4; cfgOffset = 16'd0;
    mN = 3; mD = 16; mS = 4; mOff = 0; mSr = 0; nS = 0;
    expRes = 0; expFlag = 0;
    buildH();
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    check("R10 reset result", int'(result), 0);
    check("R10 reset flag", int'(resultFlag), 0);
    check("R10 reset srReq", int'(srReq), 0);

    // R10 / R1: default third-order configuration with a random stream
    for (int i = 0; i < 120; i++) doSample(1'($urandom % 2), 1'b1, 1'b0, "R10 R1 default");

    // R1 / R4 / R8: second order, offset 5, all ones, flag cleared mid-run
    doLoad(1, 15, 4, 5, 1, "R8 load cic2");
    for (int i = 0; i < 70; i++) doSample(1'b1, 1'b1, (i == 39) ? 1'b1 : 1'b0, "R4 R1 cic2 ones");

    // R3 / R2: first order, smallest legal factor, later start, negative offset
    doLoad(0, 4, 7, -3, 1, "R2 load cic1");
    for (int i = 0; i < 60; i++)
      doSample(1'($urandom % 2), 1'b1, 1'(($urandom % 4) == 0), "R3 cic1 start7");

    // R7: disabled filter and idle strobes are ignored
    runEn = 1'b0;
    for (int i = 0; i < 20; i++) doSample(1'($urandom % 2), 1'b1, 1'b0, "R7 disabled");
    runEn = 1'b1;
    for (int i = 0; i < 40; i++)
      doSample(1'($urandom % 2), 1'(($urandom % 3) != 0), 1'b0, "R7 gaps");

    // R2 / R3 / R8: illegal loads rejected, old configuration continues
    doLoad(1, 3, 4, 0, 0, "R2 decm1 3");
    doLoad(1, 255, 4, 0, 0, "R2 decm1 255");
    doLoad(1, 15, 3, 0, 0, "R3 start 3");
    doLoad(3, 15, 4, 0, 0, "R1 order code 3");
    for (int i = 0; i < 40; i++) doSample(1'($urandom % 2), 1'b1, 1'b0, "R2 after reject");

    // R5: clear held high, results still set the flag
    doLoad(1, 7, 5, 0, 0, "R6 load sr off");
    for (int i = 0; i < 50; i++) doSample(1'($urandom % 2), 1'b1, 1'b1, "R5 clear vs set");

    // R9: full scale third order, D=255
    doLoad(2, 254, 4, 0, 1, "R9 load");
    for (int i = 0; i < 1024; i++) doSample(1'b1, 1'b1, 1'b0, "R9 full scale");
    check("R9 full-scale value", $signed(result), 16581375);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog R10 got=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule